// File: doc/BRIEF.md
# Capture/Compare Timer with DMA Request

A general-purpose timer that advances a 32-bit count on a prescaled clock. The clock source can be the system clock passed straight through, the system clock divided by sixteen, or rising edges of a separate external clock pin. In each case an 8-bit prescaler follows the source. The count runs until it equals a programmable reference. At that point a reference event fires and the compare output either pulses or toggles. The count then restarts from zero or keeps running, as configured. A separate capture input can be watched for a programmable edge, and on that edge the current count is copied into a capture register.

Each of the two events (capture and reference) sets a sticky flag. Software clears a flag by writing one to it. Each flag is routed either to a shared interrupt line or to its own DMA request line. A DMA request is retired by the matching acknowledge. While a halt input is high and freezing is enabled, the count and the prescaler both stand still. All registers can be written at any time through a simple single-cycle write port. Reads are combinational from the address.

Register map (`addr`): 0 = MODE, 1 = ROUTE, 2 = REF, 3 = CAP (read-only), 4 = CNT, 5 = EVENT.
MODE fields: `[1:0]` source (00 stopped, 01 system clock, 10 system clock ÷16, 11 external clock rising edge), `[2]` restart on match, `[3]` output mode (0 pulse, 1 toggle), `[5:4]` capture edge, `[6]` freeze enable, `[15:8]` prescale value P.
ROUTE: `[0]` capture event to DMA, `[1]` reference event to DMA.
EVENT: `[0]` capture flag, `[1]` reference flag.

Top module: `cctimer`

## Requirements
- R1: After reset, every register reads zero, and `cmp_out`, `irq` and `dma_req` are low.
- R2: Source 01 yields one source event per clock, source 10 one per 16 clocks, and source 11 one per rising edge of `ext_clk`. Source 00 yields none, so the count holds.
- R3: With prescale value P, the count advances once every P+1 source events. Starting from a CNT write, after n clocks the count is floor(n/(P+1)) for source 01 and floor(n/(16·(P+1))) for source 10.
- R4: When the count advances to the REF value, EVENT bit 1 sets in the same clock. With MODE bit 2 set, the next tick returns the count to zero.
- R5: With MODE bit 2 clear, the count keeps incrementing past REF and wraps from all ones to zero.
- R6: Capture edge encoding is 00 disabled, 01 rising, 10 falling, 11 both. A selected edge on `cap_in`, after two synchronizer flops, copies the count into CAP and sets EVENT bit 0. An edge that is not selected changes neither.
- R7: With MODE bit 3 clear, `cmp_out` is high for exactly the clock after each reference event. With it set, `cmp_out` inverts on each reference event.
- R8: Writing 1 to an EVENT bit clears that flag. Writing 0 leaves it unchanged. An event arriving in the same clock as the clear leaves the flag set.
- R9: `irq` is high whenever a flag is set whose ROUTE bit is 0.
- R10: A flag whose ROUTE bit is 1 drives its `dma_req` bit and not `irq`. The matching `dma_ack` bit clears it. An acknowledge for a flag routed to the interrupt has no effect.
- R11: While `halt` is high and MODE bit 6 is set, the count and prescaler do not advance. With MODE bit 6 clear, `halt` is ignored.
- R12: A write to CNT sets the count to zero (taking precedence over a tick in that clock) and restarts the divider and prescaler phase. REF and ROUTE accept writes at any time and read back the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| ext_clk | input | 1 | External clock source, sampled and edge-detected |
| cap_in | input | 1 | Capture trigger input (asynchronous) |
| halt | input | 1 | Debug halt; freezes the count when enabled |
| cmp_out | output | 1 | Compare output (pulse or toggle) |
| irq | output | 1 | Interrupt for flags routed to the interrupt |
| dma_req | output | 2 | DMA request per event (bit 0 capture, bit 1 reference) |
| dma_ack | input | 2 | DMA acknowledge per event |

## Verification
The assertions take `ext_clk` and `cap_in` to be slow compared with `clk`, with each level held for at least two clocks so that the synchronizers see every edge. They also take `dma_ack` to be a pulse that arrives only while its request is pending. The stimulus changes these pins only on falling clock edges and holds each level for three or more clocks. It pulses the acknowledges for a single clock. Before any capture is triggered, the count is stopped through source 00, so the expected capture value does not depend on synchronizer latency.

// File: rtl/cct_pkg.sv
package cct_pkg;

  localparam int PRE_W  = 8;
  localparam int MODE_W = 16;
  localparam int N_EVT  = 2;

  typedef enum logic [2:0] {
    A_MODE  = 3'd0,
    A_ROUTE = 3'd1,
    A_REF   = 3'd2,
    A_CAP   = 3'd3,
    A_CNT   = 3'd4,
    A_EVT   = 3'd5
  } cct_addr_e;

  typedef enum logic [1:0] {
    SRC_OFF = 2'b00,
    SRC_BUS = 2'b01,
    SRC_DIV = 2'b10,
    SRC_EXT = 2'b11
  } cct_src_e;

  typedef struct packed {
    logic [PRE_W-1:0] presc;
    logic             rsvd;
    logic             freeze;
    logic [1:0]       cap_edge;
    logic             toggle;
    logic             restart;
    logic [1:0]       src;
  } cct_mode_t;

  localparam int EV_CAP = 0;
  localparam int EV_REF = 1;

endpackage

// File: rtl/cct_tick_gen.sv
module cct_tick_gen
  import cct_pkg::*;
#(
  parameter int DIV_W  = 4,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       src,
  input  logic [PRE_W-1:0] presc,
  input  logic             frz,
  input  logic             phase_clr,
  input  logic             ext_clk,
  output logic             tick
);

  logic [SYNC_N:0]    ext_q, ext_nxt;
  logic [DIV_W-1:0]   div_q, div_nxt;
  logic [PRE_W-1:0]   pcnt_q, pcnt_nxt;
  logic               ext_rise;
  logic               src_en;

  assign ext_nxt  = {ext_q[SYNC_N-1:0], ext_clk};
  assign ext_rise = ext_q[SYNC_N-1] & ~ext_q[SYNC_N];

  always_comb begin
    src_en = 1'b0;
    case (src)
      SRC_BUS: src_en = 1'b1;
      SRC_DIV: src_en = &div_q;
      SRC_EXT: src_en = ext_rise;
      default: src_en = 1'b0;
    endcase
    if (frz) src_en = 1'b0;
  end

  always_comb begin
    div_nxt = div_q;
    if (phase_clr)                     div_nxt = '0;
    else if (src == SRC_DIV && !frz)   div_nxt = div_q + 1'b1;
  end

  always_comb begin
    pcnt_nxt = pcnt_q;
    if (phase_clr)   pcnt_nxt = '0;
    else if (src_en) pcnt_nxt = (pcnt_q == presc) ? '0 : pcnt_q + 1'b1;
  end

  assign tick = src_en && (pcnt_q == presc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_q  <= '0;
      div_q  <= '0;
      pcnt_q <= '0;
    end else begin
      ext_q  <= ext_nxt;
      div_q  <= div_nxt;
      pcnt_q <= pcnt_nxt;
    end
  end

endmodule

// File: rtl/cct_cap_in.sv
module cct_cap_in #(
  parameter int SYNC_N = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin,
  input  logic [1:0] edge_sel,
  output logic       hit
);

  logic [SYNC_N:0] sq, sq_nxt;
  logic            rise, fall;

  assign sq_nxt = {sq[SYNC_N-1:0], pin};
  assign rise   = sq[SYNC_N-1] & ~sq[SYNC_N];
  assign fall   = ~sq[SYNC_N-1] & sq[SYNC_N];
  assign hit    = (edge_sel[0] & rise) | (edge_sel[1] & fall);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sq <= '0;
    else        sq <= sq_nxt;
  end

endmodule

// File: rtl/cct_evt.sv
module cct_evt #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] wr_clr,
  input  logic [N-1:0] ack,
  input  logic [N-1:0] dma_sel,
  output logic [N-1:0] flags,
  output logic         irq,
  output logic [N-1:0] dma_req
);

  logic [N-1:0] flag_q, flag_nxt;

  for (genvar i = 0; i < N; i++) begin : g_flag
    assign flag_nxt[i] = set[i] | (flag_q[i] & ~(wr_clr[i] | (ack[i] & dma_sel[i])));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_nxt;
  end

  assign flags   = flag_q;
  assign irq     = |(flag_q & ~dma_sel);
  assign dma_req = flag_q & dma_sel;

endmodule

// File: rtl/cctimer.sv
module cctimer
  import cct_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int DIV_W  = 4,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       addr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] rdata,
  input  logic             ext_clk,
  input  logic             cap_in,
  input  logic             halt,
  output logic             cmp_out,
  output logic             irq,
  output logic [N_EVT-1:0] dma_req,
  input  logic [N_EVT-1:0] dma_ack
);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rs_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  cct_mode_t        mode_q, mode_nxt;
  logic [N_EVT-1:0] route_q, route_nxt;
  logic [CNT_W-1:0] ref_q, ref_nxt;
  logic [CNT_W-1:0] cap_q, cap_nxt;
  logic [CNT_W-1:0] cnt_q, cnt_nxt, cnt_adv;
  logic             tout_q, tout_nxt;

  logic             wr_mode, wr_route, wr_ref, cnt_wr, wr_evt;
  logic             tick, frz, cap_hit, ref_hit;
  logic [N_EVT-1:0] evt_set, evt_clr, flags;

  assign wr_mode  = wr_en && (addr == A_MODE);
  assign wr_route = wr_en && (addr == A_ROUTE);
  assign wr_ref   = wr_en && (addr == A_REF);
  assign cnt_wr   = wr_en && (addr == A_CNT);
  assign wr_evt   = wr_en && (addr == A_EVT);

  assign frz = halt && mode_q.freeze;

  cct_tick_gen #(.DIV_W(DIV_W), .SYNC_N(SYNC_N)) u_tick (
    .clk       (clk),
    .rst_n     (srst_n),
    .src       (mode_q.src),
    .presc     (mode_q.presc),
    .frz       (frz),
    .phase_clr (cnt_wr),
    .ext_clk   (ext_clk),
    .tick      (tick)
  );

  cct_cap_in #(.SYNC_N(SYNC_N)) u_cap (
    .clk      (clk),
    .rst_n    (srst_n),
    .pin      (cap_in),
    .edge_sel (mode_q.cap_edge),
    .hit      (cap_hit)
  );

  // next-state logic
  always_comb begin
    mode_nxt = mode_q;
    if (wr_mode) begin
      mode_nxt      = cct_mode_t'(wdata[MODE_W-1:0]);
      mode_nxt.rsvd = 1'b0;
    end
  end

  assign route_nxt = wr_route ? wdata[N_EVT-1:0] : route_q;
  assign ref_nxt   = wr_ref   ? wdata            : ref_q;

  assign cnt_adv = (mode_q.restart && (cnt_q == ref_q)) ? '0 : cnt_q + 1'b1;

  always_comb begin
    cnt_nxt = cnt_q;
    if (cnt_wr)    cnt_nxt = '0;
    else if (tick) cnt_nxt = cnt_adv;
  end

  assign ref_hit  = tick && !cnt_wr && (cnt_adv == ref_q);
  assign cap_nxt  = cap_hit ? cnt_q : cap_q;
  assign tout_nxt = mode_q.toggle ? (tout_q ^ ref_hit) : ref_hit;

  always_comb begin
    evt_set         = '0;
    evt_set[EV_CAP] = cap_hit;
    evt_set[EV_REF] = ref_hit;
  end
  assign evt_clr = wr_evt ? wdata[N_EVT-1:0] : '0;

  cct_evt #(.N(N_EVT)) u_evt (
    .clk     (clk),
    .rst_n   (srst_n),
    .set     (evt_set),
    .wr_clr  (evt_clr),
    .ack     (dma_ack),
    .dma_sel (route_q),
    .flags   (flags),
    .irq     (irq),
    .dma_req (dma_req)
  );

  // state registers
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      mode_q  <= '0;
      route_q <= '0;
      ref_q   <= '0;
      cap_q   <= '0;
      cnt_q   <= '0;
      tout_q  <= 1'b0;
    end else begin
      mode_q  <= mode_nxt;
      route_q <= route_nxt;
      ref_q   <= ref_nxt;
      cap_q   <= cap_nxt;
      cnt_q   <= cnt_nxt;
      tout_q  <= tout_nxt;
    end
  end

  assign cmp_out = tout_q;

  // read mux
  always_comb begin
    rdata = '0;
    case (addr)
      A_MODE:  rdata[MODE_W-1:0] = mode_q;
      A_ROUTE: rdata[N_EVT-1:0]  = route_q;
      A_REF:   rdata             = ref_q;
      A_CAP:   rdata             = cap_q;
      A_CNT:   rdata             = cnt_q;
      A_EVT:   rdata[N_EVT-1:0]  = flags;
      default: rdata             = '0;
    endcase
  end

endmodule

// File: rtl/cct_chk.sv
module cct_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             srst_n,
  input logic             frz,
  input logic             cnt_wr,
  input logic             tick,
  input logic             restart,
  input logic             toggle,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] ref_q,
  input logic [CNT_W-1:0] cap_q,
  input logic             cap_hit,
  input logic             ref_hit,
  input logic             tout,
  input logic [1:0]       flags,
  input logic [1:0]       evt_clr,
  input logic [1:0]       dma_ack,
  input logic [1:0]       route,
  input logic             irq
);

  // R11
  frz_hold_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (frz && !cnt_wr) |=> (cnt_q == $past(cnt_q)));

  // R4
  restart_zero_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (restart && tick && (cnt_q == ref_q)) |=> (cnt_q == '0));

  // R5
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (!restart && tick && (&cnt_q) && !cnt_wr) |=> (cnt_q == '0));

  // R6
  cap_load_chk: assert property (@(posedge clk) disable iff (!srst_n)
    cap_hit |=> (cap_q == $past(cnt_q)));

  // R7
  pulse_src_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (!toggle && $past(!toggle) && tout) |-> $past(ref_hit));

  // R8
  cap_flag_sticky_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (flags[0] && !evt_clr[0] && !(dma_ack[0] && route[0])) |=> flags[0]);

  // R8
  ref_flag_sticky_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (flags[1] && !evt_clr[1] && !(dma_ack[1] && route[1])) |=> flags[1]);

  // R10
  dma_no_irq_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (route == 2'b11) |-> !irq);

endmodule

bind cctimer cct_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .srst_n  (srst_n),
  .frz     (frz),
  .cnt_wr  (cnt_wr),
  .tick    (tick),
  .restart (mode_q.restart),
  .toggle  (mode_q.toggle),
  .cnt_q   (cnt_q),
  .ref_q   (ref_q),
  .cap_q   (cap_q),
  .cap_hit (cap_hit),
  .ref_hit (ref_hit),
  .tout    (tout_q),
  .flags   (flags),
  .evt_clr (evt_clr),
  .dma_ack (dma_ack),
  .route   (route_q),
  .irq     (irq)
);

// File: tb/cctimer_tb.sv
module cctimer_tb;

  localparam int CW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en;
  logic [2:0]    addr;
  logic [CW-1:0] wdata;
  logic [CW-1:0] rdata;
  logic          ext_clk, cap_in, halt;
  logic          cmp_out, irq;
  logic [1:0]    dma_req, dma_ack;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  cctimer u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .ext_clk(ext_clk), .cap_in(cap_in), .halt(halt),
    .cmp_out(cmp_out), .irq(irq), .dma_req(dma_req), .dma_ack(dma_ack)
  );

  localparam logic [2:0] MODE = 3'd0, ROUTE = 3'd1, REFR = 3'd2,
                         CAP = 3'd3, CNT = 3'd4, EVT = 3'd5;

  typedef struct packed {
    logic [1:0]  src;
    logic [7:0]  pre;
    logic [15:0] n;
    logic [31:0] exp;
  } vec_t;

  // R2 / R3 rate vectors: source, prescale, clocks waited, expected count
  localparam vec_t VECS [8] = '{
    '{2'd1, 8'd0,   16'd10,  32'd10},
    '{2'd1, 8'd3,   16'd20,  32'd5},
    '{2'd1, 8'd3,   16'd23,  32'd5},
    '{2'd1, 8'd255, 16'd600, 32'd2},
    '{2'd2, 8'd0,   16'd40,  32'd2},
    '{2'd2, 8'd1,   16'd100, 32'd3},
    '{2'd2, 8'd0,   16'd47,  32'd2},
    '{2'd0, 8'd0,   16'd50,  32'd0}
  };

  function automatic logic [31:0] mw(input logic [1:0] src, input logic rst,
                                     input logic tgl, input logic [1:0] edg,
                                     input logic frz, input logic [7:0] pre);
    return {16'b0, pre, 1'b0, frz, edg, tgl, rst, src};
  endfunction

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic chk_rd(input string tag, input logic [2:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    ext_clk = 1'b0; cap_in = 1'b0; halt = 1'b0; dma_ack = '0;
    step(3);
    rst_n = 1'b1;
    step(4);

    // R1 reset state
    for (int a = 0; a < 6; a++) chk_rd("R1 reg", 3'(a), 32'h0);
    chk("R1 cmp_out", {31'b0, cmp_out}, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 dma_req", {30'b0, dma_req}, 32'h0);

    // R2 R3 table walk
    wr(REFR, 32'hFFFF_FFFF);
    for (int i = 0; i < 8; i++) begin
      wr(MODE, mw(2'd0, 1'b0, 1'b0, 2'd0, 1'b0, VECS[i].pre));
      wr(CNT, 32'h0);
      wr(MODE, mw(VECS[i].src, 1'b0, 1'b0, 2'd0, 1'b0, VECS[i].pre));
      step(int'(VECS[i].n));
      chk_rd("R2 R3 rate", CNT, VECS[i].exp);
    end

    // R2 external clock source
    wr(MODE, mw(2'd0, 1'b0, 1'b0, 2'd0, 1'b0, 8'd0));
    wr(CNT, 32'h0);
    wr(MODE, mw(2'd3, 1'b0, 1'b0, 2'd0, 1'b0, 8'd0));
    for (int k = 0; k < 4; k++) begin
      ext_clk = 1'b1; step(3);
      ext_clk = 1'b0; step(3);
    end
    step(4);
    chk_rd("R2 ext edges", CNT, 32'd4);

    // R4 R7 restart with pulse output
    wr(MODE, mw(2'd0, 1'b1, 1'b0, 2'd0, 1'b0, 8'd0));
    wr(EVT, 32'h3);
    wr(REFR, 32'd5);
    wr(CNT, 32'h0);
    wr(MODE, mw(2'd1, 1'b1, 1'b0, 2'd0, 1'b0, 8'd0));
    step(4);
    chk("R7 no pulse before match", {31'b0, cmp_out}, 32'h0);
    step(1);
    chk_rd("R4 count at ref", CNT, 32'd5);
    chk("R7 pulse high", {31'b0, cmp_out}, 32'h1);
    chk_rd("R4 ref flag", EVT, 32'h2);
    chk("R9 irq on ref", {31'b0, irq}, 32'h1);
    step(1);
    chk_rd("R4 restart to zero", CNT, 32'd0);
    chk("R7 pulse one clock", {31'b0, cmp_out}, 32'h0);

    // R7 toggle mode
    wr(MODE, mw(2'd0, 1'b1, 1'b1, 2'd0, 1'b0, 8'd0));
    wr(REFR, 32'd2);
    wr(CNT, 32'h0);
    step(1);
    chk("R7 toggle start low", {31'b0, cmp_out}, 32'h0);
    wr(MODE, mw(2'd1, 1'b1, 1'b1, 2'd0, 1'b0, 8'd0));
    step(2);
    chk("R7 toggle first", {31'b0, cmp_out}, 32'h1);
    step(2);
    chk("R7 toggle holds", {31'b0, cmp_out}, 32'h1);
    step(1);
    chk("R7 toggle second", {31'b0, cmp_out}, 32'h0);

    // R5 free run past reference
    wr(MODE, mw(2'd0, 1'b0, 1'b0, 2'd0, 1'b0, 8'd0));
    wr(EVT, 32'h3);
    wr(REFR, 32'd3);
    wr(CNT, 32'h0);
    wr(MODE, mw(2'd1, 1'b0, 1'b0, 2'd0, 1'b0, 8'd0));
    step(5);
    chk_rd("R5 counts past ref", CNT, 32'd5);
    chk_rd("R5 ref flag set", EVT, 32'h2);

    // R6 capture edges (count stopped at 7)
    wr(EVT, 32'h3);
    wr(REFR, 32'hFFFF_FFFF);
    wr(MODE, mw(2'd0, 1'b0, 1'b0, 2'd1, 1'b0, 8'd0));
    wr(CNT, 32'h0);
    wr(MODE, mw(2'd1, 1'b0, 1'b0, 2'd1, 1'b0, 8'd0));
    step(6);
    wr(MODE, mw(2'd0, 1'b0, 1'b0, 2'd1, 1'b0, 8'd0));
    chk_rd("R6 stopped count", CNT, 32'd7);
    cap_in = 1'b1; step(4);
    chk_rd("R6 rising capture", CAP, 32'd7);
    chk_rd("R6 capture flag", EVT, 32'h1);
    chk("R9 irq on capture", {31'b0, irq}, 32'h1);
    wr(EVT, 32'h1);
    chk("R9 irq drops", {31'b0, irq}, 32'h0);
    wr(CNT, 32'h0);
    cap_in = 1'b0; step(4);
    chk_rd("R6 falling ignored flag", EVT, 32'h0);
    chk_rd("R6 falling ignored cap", CAP, 32'd7);
    wr(MODE, mw(2'd0, 1'b0, 1'b0, 2'd2, 1'b0, 8'd0));
    cap_in = 1'b1; step(4);
    chk_rd("R6 rising ignored", EVT, 32'h0);
    cap_in = 1'b0; step(4);
    chk_rd("R6 falling capture", CAP, 32'd0);
    chk_rd("R6 falling flag", EVT, 32'h1);

    // R8 write-one-to-clear
    wr(EVT, 32'h0);
    chk_rd("R8 zero write keeps", EVT, 32'h1);
    wr(EVT, 32'h2);
    chk_rd("R8 other bit keeps", EVT, 32'h1);
    wr(EVT, 32'h1);
    chk_rd("R8 one clears", EVT, 32'h0);
    wr(MODE, mw(2'd0, 1'b0, 1'b0, 2'd1, 1'b0, 8'd0));
    cap_in = 1'b1;
    step(2);
    wr(EVT, 32'h1);
    chk_rd("R8 set beats clear", EVT, 32'h1);

    // R10 ack ignored when routed to interrupt
    dma_ack = 2'b01; step(1); dma_ack = 2'b00;
    chk_rd("R10 ack ignored", EVT, 32'h1);
    wr(EVT, 32'h3);

    // R10 DMA routing of reference event
    wr(ROUTE, 32'h2);
    chk_rd("R12 route readback", ROUTE, 32'h2);
    wr(MODE, mw(2'd0, 1'b1, 1'b0, 2'd0, 1'b0, 8'd0));
    wr(REFR, 32'd3);
    wr(CNT, 32'h0);
    wr(MODE, mw(2'd1, 1'b1, 1'b0, 2'd0, 1'b0, 8'd0));
    step(3);
    wr(MODE, mw(2'd0, 1'b1, 1'b0, 2'd0, 1'b0, 8'd0));
    chk("R10 dma req", {30'b0, dma_req}, 32'h2);
    chk("R10 no irq", {31'b0, irq}, 32'h0);
    dma_ack = 2'b10; step(1); dma_ack = 2'b00;
    chk("R10 ack retires", {30'b0, dma_req}, 32'h0);
    chk_rd("R10 flag cleared", EVT, 32'h0);
    wr(ROUTE, 32'h0);

    // R11 freeze on halt
    wr(REFR, 32'hFFFF_FFFF);
    wr(MODE, mw(2'd0, 1'b0, 1'b0, 2'd0, 1'b1, 8'd0));
    wr(CNT, 32'h0);
    wr(MODE, mw(2'd1, 1'b0, 1'b0, 2'd0, 1'b1, 8'd0));
    step(3);
    halt = 1'b1;
    step(10);
    chk_rd("R11 frozen", CNT, 32'd3);
    halt = 1'b0;
    step(2);
    chk_rd("R11 resumes", CNT, 32'd5);
    wr(MODE, mw(2'd1, 1'b0, 1'b0, 2'd0, 1'b0, 8'd0));
    halt = 1'b1;
    step(4);
    chk_rd("R11 halt ignored", CNT, 32'd10);
    halt = 1'b0;

    // R12 counter write while running
    wr(CNT, 32'h1234);
    chk_rd("R12 write zeroes", CNT, 32'd0);
    wr(REFR, 32'hA5A5_0F0F);
    chk_rd("R12 ref readback", REFR, 32'hA5A5_0F0F);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule